// File: doc/BRIEF.md
# Power-up Reset Delay Sequencer

This block keeps a chip in internal reset after power-on until a fixed number of cycles of a slow on-chip RC clock has passed. It also folds in an active-low external master-clear pin. An active-high power-on pulse clears the block asynchronously. When that pulse ends, the release is brought into the RC clock domain, and an 11-bit counter then runs up to its terminal value. After that the timer reports done and stays done.

The internal reset is asserted whenever any of three things holds: the power-on pulse is still active, the timer has not reached its end, or the synchronised master clear is low. The timer has no enable and pays no attention to master clear. If master clear is held low until after the delay has run out, raising it frees the chip after only the synchroniser latency, with no second delay. A test environment can drive a fast RC clock to shorten the run.

Top module: `pwrt_seq`

## Requirements
- R1: While `por_i` is high, `rst_int_o` is 1 and `tmr_done_o` is 0, with no clock edge needed. Raising `por_i` again after the timer has finished clears `tmr_done_o` at once.
- R2: Take the rising `rc_clk` edges after `por_i` falls, numbered from 1. The first two edges release the power-on reset into the clock domain. `tmr_done_o` is then 0 after edge 2048 and becomes 1 at edge 2049, the edge at which the 11-bit count reaches 2047.
- R3: `rst_int_o` stays 1 on every cycle in which `tmr_done_o` is 0.
- R4: When master clear has been high throughout, `rst_int_o` falls on the same edge at which `tmr_done_o` rises.
- R5: `mclr_n_i` passes through a two-flop synchroniser on `rc_clk`. After a change on the pin, `rst_int_o` follows on the second rising edge and not on the first.
- R6: If `mclr_n_i` is held low until after the timer has expired, raising it releases `rst_int_o` two edges later with no further delay. If the synchronised rise lands on edge 2049, release happens on that same edge.
- R7: Toggling `mclr_n_i` while the timer is counting does not move the edge at which `tmr_done_o` rises.
- R8: Once `tmr_done_o` is 1, it stays 1 through any activity on `mclr_n_i` until the next power-on pulse.
- R9: A power-on pulse that arrives part way through the count restarts the full R2 delay from the moment that pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Slow internal RC clock that drives the timer |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| mclr_n_i | input | 1 | External master clear, active low, asynchronous |
| rst_int_o | output | 1 | Internal reset to the rest of the chip, active high |
| tmr_done_o | output | 1 | High once the power-up delay has completed |

## Verification
Two events can land on the same `rc_clk` edge: the timer reaching its terminal count, and a master-clear rise coming out of the synchroniser. The bench holds master clear low during power-up and raises it between edges 2047 and 2048, so that the synchronised rise arrives on edge 2049. It then checks that reset is still asserted after edge 2048 and drops exactly at edge 2049, together with the done flag. Neither condition may mask the other, and neither may add a cycle.

// File: rtl/pwrt_pkg.sv
package pwrt_pkg;
  // Terminal count value of a counter of the given width
  function automatic int unsigned term_of(input int unsigned width);
    return (32'd1 << width) - 32'd1;
  endfunction
endpackage

// File: rtl/pwrt_sync.sv
module pwrt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwrt_count.sv
module pwrt_count
  import pwrt_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(term_of(CNT_W));

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done_o = (cnt_q == TERM);
  assign cnt_en = ~done_o;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the count advances by one on each edge until the terminal value
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R8: done holds until the next reset
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
endmodule

// File: rtl/pwrt_seq.sv
module pwrt_seq #(
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic rc_clk,
  input  logic por_i,
  input  logic mclr_n_i,
  output logic rst_int_o,
  output logic tmr_done_o
);
  logic por_n_raw;
  logic por_rel_n;
  logic mclr_s;
  logic done_w;

  assign por_n_raw = ~por_i;

  // Power-on release: asynchronous assertion, synchronous release
  pwrt_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk    (rc_clk),
    .arst_n (por_n_raw),
    .d_i    (1'b1),
    .q_o    (por_rel_n)
  );

  // Master clear into the RC clock domain
  pwrt_sync #(.STAGES(SYNC_STAGES)) u_mclr_sync (
    .clk    (rc_clk),
    .arst_n (por_n_raw),
    .d_i    (mclr_n_i),
    .q_o    (mclr_s)
  );

  pwrt_count #(.CNT_W(CNT_W)) u_count (
    .clk    (rc_clk),
    .rst_n  (por_rel_n),
    .done_o (done_w)
  );

  assign tmr_done_o = done_w;
  assign rst_int_o  = ~por_rel_n | ~done_w | ~mclr_s;

  // R3: reset is held while the timer runs
  p_hold_r3: assert property (@(posedge rc_clk) disable iff (por_i)
    !tmr_done_o |-> rst_int_o);

  // R4: reset is only ever released once the timer is done
  p_release_r4: assert property (@(posedge rc_clk) disable iff (por_i)
    $fell(rst_int_o) |-> tmr_done_o);
endmodule

// File: tb/pwrt_seq_test.sv
module pwrt_seq_test;
  localparam int CLK_P = 10;
  localparam int DONE_EDGE = 2049;

  logic rc_clk;
  logic por_i;
  logic mclr_n_i;
  logic rst_int_o;
  logic tmr_done_o;

  int total;
  int bad;
  bit finished;

  pwrt_seq uut (
    .rc_clk     (rc_clk),
    .por_i      (por_i),
    .mclr_n_i   (mclr_n_i),
    .rst_int_o  (rst_int_o),
    .tmr_done_o (tmr_done_o)
  );

  initial rc_clk = 1'b0;
  always #(CLK_P/2) rc_clk = ~rc_clk;

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_sample();
    @(posedge rc_clk);
    #1;
  endtask

  // Pulse POR; returns at the negedge on which por_i falls
  task automatic pulse_por();
    @(negedge rc_clk);
    por_i = 1'b1;
    #1;
    chk("R1 rst during por", rst_int_o, 1'b1);
    chk("R1 done during por", tmr_done_o, 1'b0);
    repeat (3) @(negedge rc_clk);
    por_i = 1'b0;
  endtask

  // Run edges 1..n after POR release, checking the done edge
  task automatic run_to_done(input string req);
    for (int i = 1; i <= DONE_EDGE; i++) begin
      edge_sample();
      if (i == DONE_EDGE - 1) begin
        chk({req, " done low before"}, tmr_done_o, 1'b0);
        chk("R3 rst while counting", rst_int_o, 1'b1);
      end
      if (i == DONE_EDGE) chk({req, " done at edge"}, tmr_done_o, 1'b1);
    end
  endtask

  task automatic t_powerup();
    mclr_n_i = 1'b1;
    pulse_por();
    for (int i = 1; i <= DONE_EDGE; i++) begin
      edge_sample();
      if (i == 2) chk("R3 rst early", rst_int_o, 1'b1);
      if (i == DONE_EDGE - 1) begin
        chk("R2 done before terminal", tmr_done_o, 1'b0);
        chk("R3 rst before terminal", rst_int_o, 1'b1);
      end
      if (i == DONE_EDGE) begin
        chk("R2 done at terminal", tmr_done_o, 1'b1);
        chk("R4 release with done", rst_int_o, 1'b0);
      end
    end
  endtask

  task automatic t_mclr_after_done();
    @(negedge rc_clk);
    mclr_n_i = 1'b0;
    edge_sample();
    chk("R5 no reset after one edge", rst_int_o, 1'b0);
    edge_sample();
    chk("R5 reset after two edges", rst_int_o, 1'b1);
    chk("R8 done held under mclr", tmr_done_o, 1'b1);
    repeat (10) edge_sample();
    @(negedge rc_clk);
    mclr_n_i = 1'b1;
    edge_sample();
    chk("R5 still reset one edge after rise", rst_int_o, 1'b1);
    edge_sample();
    chk("R6 release after rise", rst_int_o, 1'b0);
    chk("R8 done still high", tmr_done_o, 1'b1);
  endtask

  task automatic t_mclr_held();
    mclr_n_i = 1'b0;
    pulse_por();
    run_to_done("R6");
    chk("R6 rst held by mclr", rst_int_o, 1'b1);
    repeat (20) edge_sample();
    chk("R6 rst still held", rst_int_o, 1'b1);
    @(negedge rc_clk);
    mclr_n_i = 1'b1;
    edge_sample();
    chk("R6 one edge after rise", rst_int_o, 1'b1);
    edge_sample();
    chk("R6 immediate release", rst_int_o, 1'b0);
  endtask

  task automatic t_coincide();
    mclr_n_i = 1'b0;
    pulse_por();
    for (int i = 1; i <= DONE_EDGE; i++) begin
      edge_sample();
      if (i == DONE_EDGE - 2) begin
        @(negedge rc_clk);
        mclr_n_i = 1'b1;
      end
      if (i == DONE_EDGE - 1) chk("R6 coincide rst before", rst_int_o, 1'b1);
      if (i == DONE_EDGE) begin
        chk("R6 coincide rst released", rst_int_o, 1'b0);
        chk("R2 coincide done", tmr_done_o, 1'b1);
      end
    end
  endtask

  task automatic t_mclr_toggle_count();
    mclr_n_i = 1'b1;
    pulse_por();
    for (int i = 1; i <= DONE_EDGE; i++) begin
      edge_sample();
      if (i >= 100 && i < 400 && (i % 7) == 0) begin
        @(negedge rc_clk);
        mclr_n_i = ~mclr_n_i;
      end
      if (i == 400) begin
        @(negedge rc_clk);
        mclr_n_i = 1'b1;
      end
      if (i == DONE_EDGE - 1) chk("R7 done not early", tmr_done_o, 1'b0);
      if (i == DONE_EDGE) chk("R7 done on time", tmr_done_o, 1'b1);
    end
  endtask

  task automatic t_por_restart();
    mclr_n_i = 1'b1;
    pulse_por();
    repeat (1000) edge_sample();
    pulse_por();
    run_to_done("R9");
    chk("R9 release after restart", rst_int_o, 1'b0);
    @(negedge rc_clk);
    por_i = 1'b1;
    #1;
    chk("R1 done cleared by por", tmr_done_o, 1'b0);
    chk("R1 rst by por", rst_int_o, 1'b1);
    @(negedge rc_clk);
    por_i = 1'b0;
  endtask

  initial begin
    total = 0;
    bad = 0;
    finished = 1'b0;
    por_i = 1'b1;
    mclr_n_i = 1'b1;
    repeat (3) @(negedge rc_clk);
    chk("R1 reset state rst", rst_int_o, 1'b1);
    chk("R1 reset state done", tmr_done_o, 1'b0);
    por_i = 1'b0;
    t_powerup();
    t_mclr_after_done();
    t_mclr_held();
    t_coincide();
    t_mclr_toggle_count();
    t_por_restart();
    repeat (5) @(negedge rc_clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule